// File: doc/BRIEF.md
# Indirect Register Access Window

This block is a small bridge on a 64-bit configuration port. Through it, software reaches a larger register space behind it one register at a time. Software first writes a 12-bit target address into a pointer register. Each access to the data port is then forwarded to the target register interface at that address. The block holds its own status flags, which software clears by writing ones. Two sink registers take writes and store nothing. Writes to offsets that are not decoded are dropped and reported.

The configuration port uses a valid/ready request. Each accepted request is answered by a single response pulse that carries the read data. A data-port access stalls the response until the target acknowledges. The read data from the target comes back in that same response.

Local register map: the register index is the byte address shifted right by 3. The indices are:

| Index | Register |
|-------|----------|
| 0 | pointer |
| 1 | status |
| 2 | data port |
| 3 | capability sink |
| 4 | timer sink |
| 5 to 7 | unused |

Status bit 0 flags a write to an unused offset. Status bit 1 flags a malformed access.

Control is a three-state machine:

- **ST_IDLE** accepts a request. A well-formed data-port access goes to **ST_TGT**. Every other access goes to **ST_RESP**.
- **ST_TGT** holds the target request. It stays in ST_TGT until `tgt_ack`, then moves to ST_RESP.
- **ST_RESP** drives the one-cycle response and returns to ST_IDLE.

Top module: `iwin_top`

## Requirements
- R1: After reset the pointer and status registers read zero, `req_ready` is 1, and `rsp_valid`, `tgt_valid` and `err_pulse` are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Every accepted request gets exactly one single-cycle `rsp_valid` pulse. For any register other than the data port, that pulse comes in the cycle right after acceptance.
- R3: A write to index 0 stores only bits 11:0 of the written data. A read of index 0 returns that value, zero-extended.
- R4: A read of index 2 raises `tgt_valid` with `tgt_write`=0 and `tgt_addr` equal to the pointer. The request is held with a stable address until `tgt_ack`. The response then follows in the next cycle and carries the `tgt_rdata` sampled with the acknowledge.
- R5: A write of index 2 raises `tgt_valid` with `tgt_write`=1, `tgt_addr` equal to the pointer, and `tgt_wdata` equal to the written data. The request is held until `tgt_ack`.
- R6: `req_ready` is 0 from the cycle after acceptance until the response cycle has passed. It is always 0 while `tgt_valid` is 1.
- R7: A write to index 1 clears every status bit that is 1 in the written data and leaves the other bits unchanged.
- R8: Writes to indices 3 and 4 change nothing and raise no error. Those indices read zero.
- R9: Reads of indices 5 to 7 return their stored contents, which are always zero, and raise no error.
- R10: A write to index 5, 6 or 7 changes no register and starts no target access. It sets status bit 0 and gives a one-cycle `err_pulse` together with the response, with `err_offset` equal to the index.
- R11: An access with `req_len` other than 8, or with `req_addr[2:0]` not zero, is malformed. It changes no register, starts no target access and returns zero data. It sets status bit 1 and pulses `err_pulse`, with `err_offset` equal to `req_addr[5:3]`.
- R12: A read of index 1 returns the status bits in bits 1:0 and zero above them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte address on the configuration port |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 64 | Read data, valid with `rsp_valid` |
| tgt_valid | output | 1 | Forwarded access to the target |
| tgt_write | output | 1 | Forwarded access is a write |
| tgt_addr | output | 12 | Target register address (the pointer) |
| tgt_wdata | output | 64 | Forwarded write data |
| tgt_ack | input | 1 | Target completes the forwarded access |
| tgt_rdata | input | 64 | Target read data, sampled with `tgt_ack` |
| err_pulse | output | 1 | One-cycle error strobe |
| err_offset | output | 3 | Register index of the faulting access |

## Verification
The assertions assume the requester drops `req_valid` after acceptance and issues nothing new until the response. They also assume the target raises `tgt_ack` only while `tgt_valid` is high, for a single cycle per access. The stimulus keeps within both assumptions. Each access is driven by one task that waits for the response before the next request. The target model in the bench acknowledges a pending request after a chosen delay of 0 to 3 cycles and then drops the acknowledge. Sweeps over every index, every access length and several pointer values compare the read data, the target-side fields and the error pulse against values computed in the bench.

// File: rtl/iwin_pkg.sv
package iwin_pkg;

    localparam int WORD_W   = 64;
    localparam int FULL_LEN = 8;

    // Register indices on the configuration port.
    localparam int IX_PTR   = 0;
    localparam int IX_STAT  = 1;
    localparam int IX_DATA  = 2;
    localparam int IX_CAPEN = 3;
    localparam int IX_TIMER = 4;

    // Status flag positions.
    localparam int STAT_W   = 2;
    localparam int SB_UNK   = 0;
    localparam int SB_BAD   = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TGT,
        ST_RESP
    } win_state_e;

    typedef enum logic [2:0] {
        RK_PTR,
        RK_STAT,
        RK_DATA,
        RK_SINK,
        RK_NONE
    } reg_kind_e;

endpackage

// File: rtl/iwin_decode.sv
module iwin_decode
    import iwin_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W+2:0] addr,
    input  logic [3:0]       len,
    output logic [IDX_W-1:0] idx,
    output reg_kind_e        kind,
    output logic             malformed
);

    assign idx       = addr[IDX_W+2:3];
    assign malformed = (len != 4'(FULL_LEN)) || (addr[2:0] != 3'd0);

    always_comb begin
        if (idx == IDX_W'(IX_PTR)) begin
            kind = RK_PTR;
        end else if (idx == IDX_W'(IX_STAT)) begin
            kind = RK_STAT;
        end else if (idx == IDX_W'(IX_DATA)) begin
            kind = RK_DATA;
        end else if ((idx == IDX_W'(IX_CAPEN)) || (idx == IDX_W'(IX_TIMER))) begin
            kind = RK_SINK;
        end else begin
            kind = RK_NONE;
        end
    end

endmodule

// File: rtl/iwin_regs.sv
module iwin_regs
    import iwin_pkg::*;
#(
    parameter int TA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic              stat_w1c,
    input  logic [WORD_W-1:0] wdata,
    input  logic              set_unk,
    input  logic              set_bad,
    output logic [TA_W-1:0]   ptr_q,
    output logic [STAT_W-1:0] stat_q
);

    logic [STAT_W-1:0] clr_mask;
    logic [STAT_W-1:0] set_mask;

    assign clr_mask = stat_w1c ? wdata[STAT_W-1:0] : '0;

    always_comb begin
        set_mask         = '0;
        set_mask[SB_UNK] = set_unk;
        set_mask[SB_BAD] = set_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            stat_q <= '0;
        end else begin
            if (ptr_we) begin
                ptr_q <= wdata[TA_W-1:0];
            end
            stat_q <= (stat_q & ~clr_mask) | set_mask;
        end
    end

    // R3
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |=> ptr_q == $past(wdata[TA_W-1:0]));

    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_we |=> $stable(ptr_q));

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w1c && !set_unk && !set_bad)
            |=> stat_q == ($past(stat_q) & ~$past(wdata[STAT_W-1:0])));

    // R7
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_w1c |=> ($past(stat_q) & ~stat_q) == '0);

endmodule

// File: rtl/iwin_fsm.sv
module iwin_fsm
    import iwin_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TA_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [IDX_W-1:0]  idx,
    input  reg_kind_e         kind,
    input  logic              malformed,
    input  logic [TA_W-1:0]   ptr_q,
    input  logic [STAT_W-1:0] stat_q,
    input  logic              tgt_ack,
    input  logic [WORD_W-1:0] tgt_rdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              tgt_valid,
    output logic              tgt_write,
    output logic [TA_W-1:0]   tgt_addr,
    output logic [WORD_W-1:0] tgt_wdata,
    output logic              err_pulse,
    output logic [IDX_W-1:0]  err_offset,
    output logic              ptr_we,
    output logic              stat_w1c,
    output logic              set_unk,
    output logic              set_bad
);

    win_state_e        state_q;
    win_state_e        state_d;
    logic              accept;
    logic              good;
    logic              fwd;
    logic              bad_wr;
    logic [WORD_W-1:0] local_rd;
    logic [WORD_W-1:0] rdata_q;
    logic [WORD_W-1:0] wdata_q;
    logic              wr_q;
    logic              err_q;
    logic [IDX_W-1:0]  err_off_q;

    assign accept = req_valid && (state_q == ST_IDLE);
    assign good   = accept && !malformed;
    assign fwd    = good && (kind == RK_DATA);
    assign bad_wr = good && req_write && (kind == RK_NONE);

    assign ptr_we   = good && req_write && (kind == RK_PTR);
    assign stat_w1c = good && req_write && (kind == RK_STAT);
    assign set_unk  = bad_wr;
    assign set_bad  = accept && malformed;

    always_comb begin
        local_rd = '0;
        if (!malformed && !req_write) begin
            case (kind)
                RK_PTR:  local_rd[TA_W-1:0]   = ptr_q;
                RK_STAT: local_rd[STAT_W-1:0] = stat_q;
                default: local_rd             = '0;
            endcase
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fwd) begin
                    state_d = ST_TGT;
                end else if (accept) begin
                    state_d = ST_RESP;
                end
            end
            ST_TGT: begin
                if (tgt_ack) begin
                    state_d = ST_RESP;
                end
            end
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q   <= '0;
            wdata_q   <= '0;
            wr_q      <= 1'b0;
            err_q     <= 1'b0;
            err_off_q <= '0;
        end else begin
            err_q <= (accept && malformed) || bad_wr;
            if (accept) begin
                err_off_q <= idx;
            end
            if (fwd) begin
                wr_q    <= req_write;
                wdata_q <= req_wdata;
                rdata_q <= '0;
            end else if (accept) begin
                rdata_q <= local_rd;
            end else if ((state_q == ST_TGT) && tgt_ack && !wr_q) begin
                rdata_q <= tgt_rdata;
            end
        end
    end

    // Outputs.
    always_comb begin
        req_ready = 1'b0;
        tgt_valid = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_TGT:  tgt_valid = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
            default: req_ready = 1'b0;
        endcase
    end

    assign tgt_write  = wr_q;
    assign tgt_addr   = ptr_q;
    assign tgt_wdata  = wdata_q;
    assign rsp_rdata  = rdata_q;
    assign err_pulse  = err_q;
    assign err_offset = err_off_q;

    // R4
    tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && !tgt_ack)
            |=> tgt_valid && $stable(tgt_addr) && $stable(tgt_wdata) && $stable(tgt_write));

    // R4
    tgt_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && tgt_ack) |=> rsp_valid && !tgt_valid);

    // R2
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);

    // R2
    local_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (malformed || (kind != RK_DATA))) |=> rsp_valid);

    // R6
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> !req_ready);

    // R10
    err_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    // R10
    err_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> rsp_valid);

    // R11
    bad_no_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && malformed) |=> !tgt_valid && err_pulse);

endmodule

// File: rtl/iwin_top.sv
module iwin_top
    import iwin_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TA_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [IDX_W+2:0]  req_addr,
    input  logic [3:0]        req_len,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              tgt_valid,
    output logic              tgt_write,
    output logic [TA_W-1:0]   tgt_addr,
    output logic [WORD_W-1:0] tgt_wdata,
    input  logic              tgt_ack,
    input  logic [WORD_W-1:0] tgt_rdata,
    output logic              err_pulse,
    output logic [IDX_W-1:0]  err_offset
);

    logic [IDX_W-1:0]  idx;
    reg_kind_e         kind;
    logic              malformed;
    logic [TA_W-1:0]   ptr_q;
    logic [STAT_W-1:0] stat_q;
    logic              ptr_we;
    logic              stat_w1c;
    logic              set_unk;
    logic              set_bad;

    iwin_decode #(.IDX_W(IDX_W)) u_decode (
        .addr      (req_addr),
        .len       (req_len),
        .idx       (idx),
        .kind      (kind),
        .malformed (malformed)
    );

    iwin_regs #(.TA_W(TA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_we   (ptr_we),
        .stat_w1c (stat_w1c),
        .wdata    (req_wdata),
        .set_unk  (set_unk),
        .set_bad  (set_bad),
        .ptr_q    (ptr_q),
        .stat_q   (stat_q)
    );

    iwin_fsm #(.IDX_W(IDX_W), .TA_W(TA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .idx        (idx),
        .kind       (kind),
        .malformed  (malformed),
        .ptr_q      (ptr_q),
        .stat_q     (stat_q),
        .tgt_ack    (tgt_ack),
        .tgt_rdata  (tgt_rdata),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .tgt_valid  (tgt_valid),
        .tgt_write  (tgt_write),
        .tgt_addr   (tgt_addr),
        .tgt_wdata  (tgt_wdata),
        .err_pulse  (err_pulse),
        .err_offset (err_offset),
        .ptr_we     (ptr_we),
        .stat_w1c   (stat_w1c),
        .set_unk    (set_unk),
        .set_bad    (set_bad)
    );

endmodule

// File: tb/test_iwin_top.sv
`timescale 1ns/1ps
module test_iwin_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [3:0]  req_len = 4'd8;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        tgt_valid;
    logic        tgt_write;
    logic [11:0] tgt_addr;
    logic [63:0] tgt_wdata;
    logic        tgt_ack;
    logic [63:0] tgt_rdata;
    logic        err_pulse;
    logic [2:0]  err_offset;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    iwin_top i_iwin_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .tgt_valid(tgt_valid), .tgt_write(tgt_write), .tgt_addr(tgt_addr),
        .tgt_wdata(tgt_wdata), .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata),
        .err_pulse(err_pulse), .err_offset(err_offset)
    );

    function automatic logic [63:0] seed(int i);
        return 64'h5A00_0000_0000_0000 | (64'(i) << 20) | 64'(i * 3 + 1);
    endfunction

    // Target model: a 64-entry memory with a programmable acknowledge delay.
    logic [63:0] mem [64];
    int          dly = 0;
    int          wcnt;
    logic        ack_q;
    int          tx_cnt;
    logic [11:0] last_a;
    logic        last_w;
    logic [63:0] last_d;

    assign tgt_ack   = ack_q;
    assign tgt_rdata = mem[tgt_addr[5:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= seed(i);
            ack_q  <= 1'b0;
            wcnt   <= 0;
            tx_cnt <= 0;
            last_a <= '0;
            last_w <= 1'b0;
            last_d <= '0;
        end else begin
            if (ack_q) begin
                ack_q <= 1'b0;
                wcnt  <= 0;
            end else if (tgt_valid) begin
                if (wcnt >= dly) ack_q <= 1'b1;
                else wcnt <= wcnt + 1;
            end
            if (tgt_valid && ack_q) begin
                tx_cnt <= tx_cnt + 1;
                last_a <= tgt_addr;
                last_w <= tgt_write;
                last_d <= tgt_wdata;
                if (tgt_write) mem[tgt_addr[5:0]] <= tgt_wdata;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // One access on the configuration port; returns data, error info and extra wait cycles.
    task automatic acc(input logic wr, input logic [5:0] a, input logic [3:0] ln,
                       input logic [63:0] wd, output logic [63:0] rd,
                       output logic er, output logic [2:0] eo, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_len = ln; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 ready low after accept", 64'(req_ready), 64'd0);
        lat = 0;
        while (!rsp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata; er = err_pulse; eo = err_offset;
        @(negedge clk);
        chk("R2 single response pulse", {62'd0, rsp_valid, err_pulse}, 64'd0);
        chk("R6 ready back after response", 64'(req_ready), 64'd1);
    endtask

    logic [63:0] rd;
    logic        er;
    logic [2:0]  eo;
    int          lat;

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [11:0] ptrs [5];
        int          base_tx;
        ptrs[0] = 12'h000; ptrs[1] = 12'h001; ptrs[2] = 12'h03F;
        ptrs[3] = 12'hABC; ptrs[4] = 12'hFC5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: idle outputs after reset
        chk("R1 ready after reset", 64'(req_ready), 64'd1);
        chk("R1 idle strobes", {61'd0, rsp_valid, tgt_valid, err_pulse}, 64'd0);
        // R1, R9: every local index except the data port reads zero without error
        for (int k = 0; k < 8; k++) begin
            if (k != 2) begin
                acc(1'b0, 6'(k * 8), 4'd8, '0, rd, er, eo, lat);
                chk($sformatf("R1 R9 idx %0d reads zero", k), rd, 64'd0);
                chk($sformatf("R9 idx %0d no error", k), 64'(er), 64'd0);
                chk($sformatf("R2 idx %0d latency", k), 64'(lat), 64'd0);
            end
        end

        // R3: only 12 bits of the pointer survive
        acc(1'b1, 6'd0, 4'd8, 64'hDEAD_BEEF_FFFF_FABC, rd, er, eo, lat);
        acc(1'b0, 6'd0, 4'd8, '0, rd, er, eo, lat);
        chk("R3 pointer masked to 12 bits", rd, 64'h0000_0000_0000_0ABC);

        // R4, R5: sweep pointers and acknowledge delays
        for (int p = 0; p < 5; p++) begin
            acc(1'b1, 6'd0, 4'd8, {52'hFFF_FFFF_FFFF_F, ptrs[p]}, rd, er, eo, lat);
            acc(1'b0, 6'd0, 4'd8, '0, rd, er, eo, lat);
            chk("R3 pointer readback", rd, 64'(ptrs[p]));
            for (int d = 0; d < 4; d++) begin
                dly = d;
                acc(1'b0, 6'd16, 4'd8, '0, rd, er, eo, lat);
                chk("R4 data port read value", rd, seed(int'(ptrs[p][5:0])));
                chk("R4 read latency follows ack", 64'(lat), 64'(d + 2));
                chk("R4 target address", 64'(last_a), 64'(ptrs[p]));
                chk("R4 target read flag", 64'(last_w), 64'd0);
            end
            dly = p % 4;
            acc(1'b1, 6'd16, 4'd8, ~seed(p), rd, er, eo, lat);
            chk("R5 target write flag", 64'(last_w), 64'd1);
            chk("R5 target write data", last_d, ~seed(p));
            chk("R5 target write address", 64'(last_a), 64'(ptrs[p]));
            chk("R5 no error on data write", 64'(er), 64'd0);
            acc(1'b0, 6'd16, 4'd8, '0, rd, er, eo, lat);
            chk("R5 written value reads back", rd, ~seed(p));
        end

        // R8: sink registers discard writes
        for (int k = 3; k < 5; k++) begin
            acc(1'b1, 6'(k * 8), 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, rd, er, eo, lat);
            chk("R8 sink write no error", 64'(er), 64'd0);
            acc(1'b0, 6'(k * 8), 4'd8, '0, rd, er, eo, lat);
            chk("R8 sink reads zero", rd, 64'd0);
        end
        acc(1'b0, 6'd8, 4'd8, '0, rd, er, eo, lat);
        chk("R8 status untouched by sinks", rd, 64'd0);
        acc(1'b0, 6'd0, 4'd8, '0, rd, er, eo, lat);
        chk("R8 pointer untouched by sinks", rd, 64'h0000_0000_0000_0FC5);

        // R10: writes to unused offsets
        for (int k = 5; k < 8; k++) begin
            base_tx = tx_cnt;
            acc(1'b1, 6'(k * 8), 4'd8, 64'h1234_5678_9ABC_DEF0, rd, er, eo, lat);
            chk("R10 error pulse", 64'(er), 64'd1);
            chk("R10 error offset", 64'(eo), 64'(k));
            chk("R10 no target access", 64'(tx_cnt - base_tx), 64'd0);
            acc(1'b0, 6'(k * 8), 4'd8, '0, rd, er, eo, lat);
            chk("R9 unused still zero", rd, 64'd0);
        end
        acc(1'b0, 6'd8, 4'd8, '0, rd, er, eo, lat);
        chk("R10 R12 status bit0 set", rd, 64'd1);
        acc(1'b0, 6'd0, 4'd8, '0, rd, er, eo, lat);
        chk("R10 pointer unchanged", rd, 64'h0000_0000_0000_0FC5);

        // R11: malformed accesses (bad length sweep and misaligned)
        for (int l = 0; l < 16; l++) begin
            if (l != 8) begin
                base_tx = tx_cnt;
                acc(1'b1, 6'd16, 4'(l), 64'hAAAA_AAAA_AAAA_AAAA, rd, er, eo, lat);
                chk($sformatf("R11 len %0d error", l), 64'(er), 64'd1);
                chk("R11 error offset", 64'(eo), 64'd2);
                chk("R11 no target access", 64'(tx_cnt - base_tx), 64'd0);
            end
        end
        acc(1'b1, 6'd3, 4'd8, 64'h0000_0000_0000_0111, rd, er, eo, lat);
        chk("R11 misaligned error", 64'(er), 64'd1);
        chk("R11 misaligned offset", 64'(eo), 64'd0);
        acc(1'b0, 6'd1, 4'd8, '0, rd, er, eo, lat);
        chk("R11 misaligned read returns zero", rd, 64'd0);
        acc(1'b0, 6'd0, 4'd8, '0, rd, er, eo, lat);
        chk("R11 pointer unchanged", rd, 64'h0000_0000_0000_0FC5);
        acc(1'b0, 6'd8, 4'd8, '0, rd, er, eo, lat);
        chk("R11 R12 both status bits", rd, 64'd3);

        // R7: write-one-to-clear
        acc(1'b1, 6'd8, 4'd8, 64'd2, rd, er, eo, lat);
        acc(1'b0, 6'd8, 4'd8, '0, rd, er, eo, lat);
        chk("R7 clear bit1 only", rd, 64'd1);
        acc(1'b1, 6'd8, 4'd8, 64'd0, rd, er, eo, lat);
        acc(1'b0, 6'd8, 4'd8, '0, rd, er, eo, lat);
        chk("R7 zero write keeps bits", rd, 64'd1);
        acc(1'b1, 6'd8, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, rd, er, eo, lat);
        chk("R7 status write no error", 64'(er), 64'd0);
        acc(1'b0, 6'd8, 4'd8, '0, rd, er, eo, lat);
        chk("R7 all cleared", rd, 64'd0);

        summary();
        $finish;
    end

endmodule